// File: doc/BRIEF.md
# Eight-bit multicycle accumulator processor

This block is a small processor core with 8-bit data, 8-bit addresses and a unified 256-byte memory held inside the block. Every instruction is two bytes long. A step sequencer reads the two bytes one at a time into holding registers. Decode and execute happen only once both bytes are present. Control therefore depends on the sequencer step as well as on the opcode.

There are eight general registers. Two-operand arithmetic and logic results are not written to a named destination. They go to an accumulator, and a separate instruction copies the accumulator into a chosen register. The instruction set covers immediate loads, memory loads and stores, AND, OR, NOT, add, subtract, an absolute jump, and branches on zero and on negative. A halt instruction freezes the core and raises a done flag.

A testbench or a loader fills memory through a separate load port while the core is held in reset. After the program halts, it reads back registers and memory through registered monitor ports.

Top module: `acc_cpu8`

Instruction layout: byte 0 holds the opcode in bits 7:4, register A in bits 3:1 and an unused bit 0. Byte 1 holds an immediate value or address, and its bits 2:0 name register B. Opcodes: 0 no-op, 1 load immediate, 2 load from memory, 3 store, 4 copy accumulator to register, 5 add, 6 subtract, 7 AND, 8 OR, 9 NOT, A jump, B branch if zero, C branch if negative, F halt.

## Requirements
- R1: While reset is high, the PC, the accumulator and all eight registers are cleared, and done is low.
- R2: After reset, an instruction completes on the 4th rising edge after it starts, and a memory load completes on the 5th. PC and accumulator updates become visible at that edge.
- R3: Opcode 1 writes byte 1 into register A.
- R4: Opcode 2 copies memory[byte 1] into register A. Opcode 3 writes register A into memory[byte 1].
- R5: Opcodes 5/6/7/8 place A+B, A−B (two's complement, modulo 256), A AND B and A OR B into the accumulator. Opcode 9 places NOT A there.
- R6: Opcode 4 copies the accumulator into register A. Only opcodes 5 to 9 change the accumulator.
- R7: Every instruction other than a taken jump or branch, or halt, advances the PC by 2, wrapping modulo 256.
- R8: Opcode A loads the PC with byte 1.
- R9: Opcode B loads the PC with byte 1 only if register A is zero. Opcode C does so only if bit 7 of register A is set. Otherwise the PC advances by 2.
- R10: Opcode F raises done when it completes. From then on, the PC, the accumulator, the registers and memory no longer change.
- R11: Opcodes D and E, and the unused bit 0 of byte 0, have no effect beyond advancing the PC.
- R12: The load port writes memory[ld_addr] when ld_we is high. ld_rdata and mon_reg show memory[ld_addr] and register[mon_sel] one rising edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load port write enable |
| ld_addr | input | 8 | Load/monitor memory address |
| ld_wdata | input | 8 | Load port write data |
| ld_rdata | output | 8 | Registered memory read at ld_addr |
| mon_sel | input | 3 | Register select for monitoring |
| mon_reg | output | 8 | Registered register value |
| pc_o | output | 8 | Program counter |
| acc_o | output | 8 | Accumulator |
| done | output | 1 | Halt reached |

## Verification
The hardest situation to reach from the ports is the PC wrapping from 0xFE back to 0x00 in the middle of a program, combined with a branch that is taken on one pass and not on the next. A dedicated program jumps to the top of memory, runs two immediate loads there and wraps. It then re-executes a branch on zero whose register has meanwhile become non-zero. A countdown loop exercises repeated taken and untaken branches, and a negative-branch sequence creates 0xFF by subtraction. A behavioural model runs in lock step, so any cycle-count slip in fetch, load or halt shows up at once on the PC, the accumulator or done.

// File: rtl/acc_cpu8_pkg.sv
package acc_cpu8_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_LDI  = 4'h1,
    OP_LD   = 4'h2,
    OP_ST   = 4'h3,
    OP_MOVA = 4'h4,
    OP_ADD  = 4'h5,
    OP_SUB  = 4'h6,
    OP_AND  = 4'h7,
    OP_OR   = 4'h8,
    OP_NOT  = 4'h9,
    OP_JMP  = 4'hA,
    OP_BZ   = 4'hB,
    OP_BN   = 4'hC,
    OP_RSVD = 4'hD,
    OP_RSVE = 4'hE,
    OP_HALT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_F0   = 3'd0,
    ST_F1   = 3'd1,
    ST_F2   = 3'd2,
    ST_EX   = 3'd3,
    ST_MEM  = 3'd4,
    ST_HALT = 3'd5
  } step_e;

endpackage

// File: rtl/acc_cpu8_seq.sv
module acc_cpu8_seq
  import acc_cpu8_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e op,
  output step_e   step,
  output logic    done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_F0;
      done <= 1'b0;
    end else begin
      case (step)
        ST_F0:   step <= ST_F1;
        ST_F1:   step <= ST_F2;
        ST_F2:   step <= ST_EX;
        ST_EX: begin
          if (op == OP_LD) begin
            step <= ST_MEM;
          end else if (op == OP_HALT) begin
            step <= ST_HALT;
            done <= 1'b1;
          end else begin
            step <= ST_F0;
          end
        end
        ST_MEM:  step <= ST_F0;
        ST_HALT: step <= ST_HALT;
        default: step <= ST_F0;
      endcase
    end
  end

  // R2: the second byte is always fetched right after the first
  assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
    (step == ST_F0) |=> (step == ST_F1));

  // R10: once halted the sequencer stays halted with done raised
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (step == ST_HALT) |=> (step == ST_HALT && done));

endmodule

// File: rtl/acc_cpu8_alu.sv
module acc_cpu8_alu
  import acc_cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  opcode_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_NOT:  y = ~a;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/acc_cpu8_rf.sv
module acc_cpu8_rf #(
  parameter  int DW   = 8,
  parameter  int NREG = 8,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] sel_a,
  input  logic [RW-1:0] sel_b,
  input  logic [RW-1:0] sel_m,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] rd_m
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wsel] <= wdata;
    end
  end

  assign rd_a = regs[sel_a];
  assign rd_b = regs[sel_b];

  always_ff @(posedge clk) rd_m <= regs[sel_m];

endmodule

// File: rtl/acc_cpu8_mem.sv
module acc_cpu8_mem #(
  parameter  int AW    = 8,
  parameter  int DW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we) begin
      ram[b_addr] <= b_wdata;
    end else if (a_we) begin
      ram[a_addr] <= a_wdata;
    end
    a_rdata <= ram[a_addr];
    b_rdata <= ram[b_addr];
  end

endmodule

// File: rtl/acc_cpu8.sv
module acc_cpu8
  import acc_cpu8_pkg::*;
#(
  parameter  int DW   = 8,
  parameter  int AW   = 8,
  parameter  int NREG = 8,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  output logic [DW-1:0] ld_rdata,
  input  logic [RW-1:0] mon_sel,
  output logic [DW-1:0] mon_reg,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          done
);

  localparam logic [AW-1:0] PC_ONE = AW'(1);
  localparam logic [AW-1:0] PC_TWO = AW'(2);

  step_e         step;
  logic [AW-1:0] pc, pc_nx;
  logic [DW-1:0] acc;
  logic [DW-2:0] ir0;
  logic [DW-1:0] ir1;
  opcode_e       op;
  logic [RW-1:0] ra, rb;
  logic [AW-1:0] imm_addr;
  logic [DW-1:0] rd_a, rd_b, alu_y;
  logic          rf_we, acc_we, mem_we;
  logic [DW-1:0] rf_wd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;

  assign op       = opcode_e'(ir0[DW-2 -: 4]);
  assign ra       = ir0[RW-1:0];
  assign rb       = ir1[RW-1:0];
  assign imm_addr = ir1[AW-1:0];

  acc_cpu8_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .op   (op),
    .step (step),
    .done (done)
  );

  acc_cpu8_rf #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .wsel  (ra),
    .wdata (rf_wd),
    .sel_a (ra),
    .sel_b (rb),
    .sel_m (mon_sel),
    .rd_a  (rd_a),
    .rd_b  (rd_b),
    .rd_m  (mon_reg)
  );

  acc_cpu8_alu #(.DW(DW)) u_alu (
    .op (op),
    .a  (rd_a),
    .b  (rd_b),
    .y  (alu_y)
  );

  acc_cpu8_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .a_addr  (mem_addr),
    .a_we    (mem_we),
    .a_wdata (rd_a),
    .a_rdata (mem_rdata),
    .b_addr  (ld_addr),
    .b_we    (ld_we),
    .b_wdata (ld_wdata),
    .b_rdata (ld_rdata)
  );

  always_comb begin
    pc_nx    = pc;
    acc_we   = 1'b0;
    rf_we    = 1'b0;
    rf_wd    = acc;
    mem_we   = 1'b0;
    mem_addr = pc;
    case (step)
      ST_F1: mem_addr = pc + PC_ONE;
      ST_EX: begin
        mem_addr = imm_addr;
        pc_nx    = pc + PC_TWO;
        case (op)
          OP_LDI: begin
            rf_we = 1'b1;
            rf_wd = ir1;
          end
          OP_LD:   pc_nx  = pc;
          OP_ST:   mem_we = !rst;
          OP_MOVA: rf_we  = 1'b1;
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT: acc_we = 1'b1;
          OP_JMP:  pc_nx = imm_addr;
          OP_BZ:   if (rd_a == '0) pc_nx = imm_addr;
          OP_BN:   if (rd_a[DW-1]) pc_nx = imm_addr;
          OP_HALT: pc_nx = pc;
          default: ;
        endcase
      end
      ST_MEM: begin
        mem_addr = imm_addr;
        rf_we    = 1'b1;
        rf_wd    = mem_rdata;
        pc_nx    = pc + PC_TWO;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      acc <= '0;
      ir0 <= '0;
      ir1 <= '0;
    end else begin
      if (step == ST_F1) ir0 <= mem_rdata[DW-1:1];
      if (step == ST_F2) ir1 <= mem_rdata;
      pc <= pc_nx;
      if (acc_we) acc <= alu_y;
    end
  end

  assign pc_o  = pc;
  assign acc_o = acc;

  // R7: straight-line instructions step the PC by two
  assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EX && (op == OP_ADD || op == OP_LDI || op == OP_MOVA))
      |=> (pc == $past(pc) + PC_TWO));

  // R5: difference in the accumulator plus B gives back A
  assert_sub_R5: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EX && op == OP_SUB) |=> ((acc + $past(rd_b)) == $past(rd_a)));

  // R9: branch on zero with a non-zero register falls through
  assert_bz_fall_R9: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EX && op == OP_BZ && rd_a != '0) |=> (pc == $past(pc) + PC_TWO));

  // R10: halted core keeps PC and accumulator frozen
  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(pc) && $stable(acc)));

  // R6: the accumulator only moves on an execute step
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (step != ST_EX) |=> $stable(acc));

endmodule

// File: tb/sim_acc_cpu8.sv
module sim_acc_cpu8;

  logic       clk = 1'b0;
  logic       rst;
  logic       ld_we;
  logic [7:0] ld_addr, ld_wdata, ld_rdata;
  logic [2:0] mon_sel;
  logic [7:0] mon_reg, pc_o, acc_o;
  logic       done;

  int tests = 0;
  int fails = 0;
  logic lockstep = 1'b0;

  logic [7:0] img [256];
  logic [7:0] mm  [256];
  logic [7:0] mr  [8];
  logic [7:0] mpc, macc;
  logic       mdone;
  int         mcnt;

  always #2ns clk = ~clk;

  acc_cpu8 u0 (
    .clk      (clk),
    .rst      (rst),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_wdata (ld_wdata),
    .ld_rdata (ld_rdata),
    .mon_sel  (mon_sel),
    .mon_reg  (mon_reg),
    .pc_o     (pc_o),
    .acc_o    (acc_o),
    .done     (done)
  );

  // behavioural reference: counts cycles per instruction, applies effect at the end
  always @(posedge clk) begin : model
    logic [7:0] b0, b1, npc;
    logic [3:0] op;
    logic [2:0] ra, rb;
    int len;
    if (rst) begin
      mpc = 0; macc = 0; mdone = 0; mcnt = 0;
      for (int i = 0; i < 8; i++) mr[i] = 0;
    end else if (!mdone) begin
      b0 = mm[mpc];
      b1 = mm[8'(mpc + 8'd1)];
      op = b0[7:4]; ra = b0[3:1]; rb = b1[2:0];
      len = (op == 4'h2) ? 5 : 4;
      mcnt++;
      if (mcnt == len) begin
        mcnt = 0;
        npc = 8'(mpc + 8'd2);
        case (op)
          4'h1: mr[ra] = b1;
          4'h2: mr[ra] = mm[b1];
          4'h3: mm[b1] = mr[ra];
          4'h4: mr[ra] = macc;
          4'h5: macc = 8'(mr[ra] + mr[rb]);
          4'h6: macc = 8'(mr[ra] - mr[rb]);
          4'h7: macc = mr[ra] & mr[rb];
          4'h8: macc = mr[ra] | mr[rb];
          4'h9: macc = ~mr[ra];
          4'hA: npc = b1;
          4'hB: if (mr[ra] == 8'h00) npc = b1;
          4'hC: if (mr[ra][7]) npc = b1;
          4'hF: begin npc = mpc; mdone = 1; end
          default: ;
        endcase
        mpc = npc;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // R2: lock-step comparison of PC, accumulator and done on every clock
  always @(negedge clk) begin
    if (lockstep && !rst) begin
      check("R2", "pc lockstep", pc_o, mpc);
      check("R2", "acc lockstep", acc_o, macc);
      check("R2", "done lockstep", {7'd0, done}, {7'd0, mdone});
    end
  end

  task automatic put(input int a, input logic [7:0] b0, input logic [7:0] b1);
    img[a] = b0;
    img[(a + 1) % 256] = b1;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  task automatic load_and_reset();
    lockstep = 1'b0;
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      ld_we = 1'b1; ld_addr = 8'(i); ld_wdata = img[i];
      mm[i] = img[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", pc_o, 8'h00);
    check("R1", "acc in reset", acc_o, 8'h00);
    check("R1", "done in reset", {7'd0, done}, 8'h00);
    for (int r = 0; r < 8; r++) begin
      mon_sel = 3'(r);
      @(negedge clk);
      check("R1", $sformatf("reg %0d in reset", r), mon_reg, 8'h00);
    end
  endtask

  task automatic run_prog();
    logic [7:0] pc_hold;
    lockstep = 1'b1;
    rst = 1'b0;
    for (int c = 0; c < 4000 && !done; c++) @(negedge clk);
    check("R10", "done raised", {7'd0, done}, 8'h01);
    pc_hold = pc_o;
    repeat (6) @(negedge clk);
    check("R10", "pc frozen after halt", pc_o, pc_hold);
  endtask

  task automatic reg_is(input string req, input int r, input logic [7:0] exp);
    mon_sel = 3'(r);
    @(negedge clk);
    check(req, $sformatf("reg %0d", r), mon_reg, exp);
  endtask

  task automatic mem_is(input string req, input logic [7:0] a, input logic [7:0] exp);
    ld_addr = a;
    @(negedge clk);
    check(req, $sformatf("mem %02h", a), ld_rdata, exp);
  endtask

  initial begin : watchdog
    #800us;
    tests++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; ld_we = 1'b0; ld_addr = 8'h00; ld_wdata = 8'h00; mon_sel = 3'd0;
    repeat (3) @(negedge clk);

    // program 1: data movement, ALU, load/store, reserved opcode
    clear_img();
    put(0,  8'h12, 8'h5A);  // LDI R1,5A
    put(2,  8'h14, 8'h0F);  // LDI R2,0F
    put(4,  8'h72, 8'h02);  // AND R1,R2
    put(6,  8'h46, 8'h00);  // MOVA R3
    put(8,  8'h82, 8'h02);  // OR R1,R2
    put(10, 8'h48, 8'h00);  // MOVA R4
    put(12, 8'h92, 8'h00);  // NOT R1
    put(14, 8'h4A, 8'h00);  // MOVA R5
    put(16, 8'h64, 8'h01);  // SUB R2,R1
    put(18, 8'h4C, 8'h00);  // MOVA R6
    put(20, 8'h52, 8'h01);  // ADD R1,R1
    put(22, 8'h4E, 8'h00);  // MOVA R7
    put(24, 8'h3E, 8'h80);  // ST R7,[80]
    put(26, 8'h20, 8'h80);  // LD R0,[80]
    put(28, 8'hD1, 8'hFF);  // reserved opcode, spare bit set
    put(30, 8'hF0, 8'h00);  // HALT
    load_and_reset();
    mem_is("R12", 8'h1A, 8'h20);
    run_prog();
    reg_is("R3", 1, 8'h5A);
    reg_is("R3", 2, 8'h0F);
    reg_is("R5", 3, 8'h0A);
    reg_is("R5", 4, 8'h5F);
    reg_is("R5", 5, 8'hA5);
    reg_is("R5", 6, 8'hB5);
    reg_is("R6", 7, 8'hB4);
    reg_is("R4", 0, 8'hB4);
    mem_is("R4", 8'h80, 8'hB4);
    check("R11", "acc after reserved opcode", acc_o, 8'hB4);
    check("R11", "halt reached past reserved opcode", pc_o, 8'h1E);

    // program 2: countdown loop, branch on zero and on negative
    clear_img();
    put(0,  8'h12, 8'h03);  // LDI R1,3
    put(2,  8'h14, 8'h01);  // LDI R2,1
    put(4,  8'h16, 8'h00);  // LDI R3,0
    put(6,  8'hB2, 8'h14);  // BZ R1,20
    put(8,  8'h62, 8'h02);  // SUB R1,R2
    put(10, 8'h42, 8'h00);  // MOVA R1
    put(12, 8'h56, 8'h02);  // ADD R3,R2
    put(14, 8'h46, 8'h00);  // MOVA R3
    put(16, 8'hA0, 8'h06);  // JMP 6
    put(20, 8'hC8, 8'h40);  // BN R4,40 (not taken)
    put(22, 8'h68, 8'h02);  // SUB R4,R2
    put(24, 8'h48, 8'h00);  // MOVA R4
    put(26, 8'hC8, 8'h20);  // BN R4,32 (taken)
    put(28, 8'h1A, 8'hEE);  // LDI R5,EE (skipped)
    put(30, 8'hF0, 8'h00);  // HALT (skipped)
    put(32, 8'h1C, 8'h77);  // LDI R6,77
    put(34, 8'hF0, 8'h00);  // HALT
    load_and_reset();
    run_prog();
    reg_is("R9", 1, 8'h00);
    reg_is("R8", 3, 8'h03);
    reg_is("R5", 4, 8'hFF);
    reg_is("R9", 5, 8'h00);
    reg_is("R9", 6, 8'h77);
    check("R9", "final pc", pc_o, 8'h22);

    // program 3: PC wrap at the top of memory
    clear_img();
    put(0,   8'hB4, 8'h10);  // BZ R2,10
    put(2,   8'hF0, 8'h00);  // HALT
    put(16,  8'hA0, 8'hFC);  // JMP FC
    put(252, 8'h12, 8'h11);  // LDI R1,11
    put(254, 8'h14, 8'h22);  // LDI R2,22 then wrap
    load_and_reset();
    run_prog();
    reg_is("R7", 1, 8'h11);
    reg_is("R7", 2, 8'h22);
    check("R7", "pc after wrap", pc_o, 8'h02);

    lockstep = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule